// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Alarm

This core keeps wall-clock time and a calendar in packed BCD registers. A fast strobe `pre_tick` is divided by a parameterised prescaler into a once-per-second event. Each second event advances seconds, minutes, hours, weekday, day of month, month and a two-digit year. All carries are handled, including the length of each month and February in leap years.

Hours can be kept in 24-hour form, or in 12-hour form with a PM flag. A minute/hour alarm with a per-weekday mask raises a sticky flag and an active-low interrupt. An optional once-per-second flag drives a second interrupt. An oscillator-stop flag comes up set after reset and stays set until software clears it, which tells software that the time is not trustworthy.

Software reaches every register through a flat port with 16 byte addresses. Writes take effect on the clock edge. Reads are combinational from the current address.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00, minutes 0x00, hour 0x12, weekday 0, day 0x01, month 0x01, year 0x00, trim 0x00, all alarm registers 0x00, control1 0x00 and control2 0x10. Both interrupt outputs are high.
- R2: The seconds register advances once per TICKS_PER_SEC pulses of `pre_tick`. A write to the seconds register (address 0) restarts the prescaler, so a full TICKS_PER_SEC pulses pass before the next advance.
- R3: Seconds and minutes count BCD 00 to 59. At 59 the field wraps to 00 and carries into the next field.
- R4: In 24-hour mode (control1 bit 5 = 1), the hour counts BCD 0x00 to 0x23. The step from 0x23 to 0x00 carries into the day.
- R5: In 12-hour mode (control1 bit 5 = 0), the hour holds BCD 1 to 12 in bits 4:0 and PM in bit 5. The steps are: 0x11 to 0x32 (11 AM to noon), 0x32 to 0x21, 0x12 to 0x01, and 0x31 to 0x12 (11 PM to midnight). Only the last of these carries into the day.
- R6: The day wraps to 0x01 and increments the month after 0x30 in months 04, 06, 09 and 11, and after 0x31 in the other months.
- R7: February ends at 0x29 when the two-digit year is a multiple of four, 00 included, and at 0x28 otherwise.
- R8: The weekday counts 0 to 6 and wraps to 0. Month 0x12 wraps to 0x01 and increments the year. Year 0x99 wraps to 0x00.
- R9: The oscillator-stop flag is control2 bit 4. Reset sets it. Writing 0 to that bit clears it, and writing 1 never sets it.
- R10: The alarm flag is control2 bit 1. It is set when seconds roll from 59 to 00 and all of the following hold: alarm enable (control1 bit 7) is set, the new minute equals address 8, the new hour equals address 9, and bit [weekday] of the mask at address 10 is set. `alarm_irq_n` is low while both the flag and the enable are set. Writing 0 to the flag clears it, and the alarm fires once per match.
- R11: A clear mask bit for the current weekday suppresses the alarm, and so does a clear enable. Writing control1 with bit 7 = 0 also clears a pending alarm flag.
- R12: With control1 bits 2:0 = 4, every second sets the periodic flag (control2 bit 2), and `periodic_irq_n` is low while the flag is set and the select is 4. With a select of 0 no flag is set. Writing 0 to the flag clears it.
- R13: Writes are masked to the field widths: seconds and minutes 7 bits, hour 6, weekday 3, day 6, month 5, year 8, trim 8, alarm minute 7, alarm hour 6, alarm mask 7, control1 bits 7, 5 and 2:0. Addresses 11 to 13 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_tick | input | 1 | One-cycle prescaler strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| alarm_irq_n | output | 1 | Active-low alarm interrupt |
| periodic_irq_n | output | 1 | Active-low once-per-second interrupt |

## Verification
Every result in this block lands on a single clock edge:
- A register write is visible on `reg_rdata` right after the edge on which `reg_we` was sampled.
- A time advance, together with any alarm or periodic flag and its interrupt, appears right after the edge that samples the TICKS_PER_SEC-th `pre_tick` pulse.

The bench drives all inputs on falling edges. It samples one time unit after a falling edge, once the last pulse of a second has been taken. Each scenario therefore reads the new calendar values exactly one second after loading the time just before a carry boundary.

// File: rtl/tk_pkg.sv
package tk_pkg;

  localparam logic [3:0] A_SEC   = 4'd0;
  localparam logic [3:0] A_MIN   = 4'd1;
  localparam logic [3:0] A_HOUR  = 4'd2;
  localparam logic [3:0] A_WDAY  = 4'd3;
  localparam logic [3:0] A_DAY   = 4'd4;
  localparam logic [3:0] A_MON   = 4'd5;
  localparam logic [3:0] A_YEAR  = 4'd6;
  localparam logic [3:0] A_TRIM  = 4'd7;
  localparam logic [3:0] A_AMIN  = 4'd8;
  localparam logic [3:0] A_AHOUR = 4'd9;
  localparam logic [3:0] A_AMASK = 4'd10;
  localparam logic [3:0] A_CTRL1 = 4'd14;
  localparam logic [3:0] A_CTRL2 = 4'd15;

  localparam int C1_ALM_EN = 7;
  localparam int C1_MODE24 = 5;
  localparam int C2_OSC    = 4;
  localparam int C2_PER    = 2;
  localparam int C2_ALM    = 1;
  localparam logic [2:0] PER_SEL_1HZ = 3'd4;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } tk_time_t;

  localparam tk_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h12,
                                    wday: 8'h00, day: 8'h01, mon: 8'h01,
                                    year: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // multiple of four, judged on the two BCD digits directly
  function automatic logic leap_year(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // returns {day_carry, next_hour}
  function automatic logic [8:0] hour_step(input logic [7:0] h, input logic mode24);
    logic [7:0] v;
    logic       pm;
    v  = {3'b000, h[4:0]};
    pm = h[5];
    if (mode24) begin
      if (h == 8'h23) return {1'b1, 8'h00};
      return {1'b0, bcd_inc(h)};
    end
    if (v == 8'h11) return {pm, 2'b00, ~pm, 5'h12};
    if (v == 8'h12) return {1'b0, 2'b00, pm, 5'h01};
    return {1'b0, 2'b00, pm, bcd_inc(v)[4:0]};
  endfunction

  function automatic tk_time_t cal_next(input tk_time_t t, input logic mode24);
    tk_time_t   n;
    logic [8:0] hs;
    n = t;
    if (t.sec == 8'h59) begin
      n.sec = 8'h00;
      if (t.min == 8'h59) begin
        n.min  = 8'h00;
        hs     = hour_step(t.hour, mode24);
        n.hour = hs[7:0];
        if (hs[8]) begin
          n.wday = (t.wday >= 8'd6) ? 8'd0 : t.wday + 8'd1;
          if (t.day == last_day(t.mon, t.year)) begin
            n.day = 8'h01;
            if (t.mon == 8'h12) begin
              n.mon  = 8'h01;
              n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
            end else begin
              n.mon = bcd_inc(t.mon);
            end
          end else begin
            n.day = bcd_inc(t.day);
          end
        end
      end else begin
        n.min = bcd_inc(t.min);
      end
    end else begin
      n.sec = bcd_inc(t.sec);
    end
    return n;
  endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_tick,
  input  logic restart,
  output logic sec_tick
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  generate
    if (TICKS_PER_SEC > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (restart)           cnt_q <= '0;
        else if (pre_tick)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      assign sec_tick = pre_tick && !restart && (cnt_q == LAST);

      a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
      a_r2_restart_delays: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sec_tick);
    end else begin : g_pass
      assign sec_tick = pre_tick && !restart;
    end
  endgenerate
endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
  import tk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode24,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output tk_time_t   cur,
  output tk_time_t   nxt
);
  tk_time_t t_q;

  assign cur = t_q;
  assign nxt = cal_next(t_q, mode24);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= TIME_RST;
    end else if (we) begin
      case (addr)
        A_SEC:   t_q.sec  <= wdata & 8'h7F;
        A_MIN:   t_q.min  <= wdata & 8'h7F;
        A_HOUR:  t_q.hour <= wdata & 8'h3F;
        A_WDAY:  t_q.wday <= wdata & 8'h07;
        A_DAY:   t_q.day  <= wdata & 8'h3F;
        A_MON:   t_q.mon  <= wdata & 8'h1F;
        A_YEAR:  t_q.year <= wdata;
        default: if (tick) t_q <= nxt;
      endcase
    end else if (tick) begin
      t_q.sec  <= nxt.sec  & 8'h7F;
      t_q.min  <= nxt.min  & 8'h7F;
      t_q.hour <= nxt.hour & 8'h3F;
      t_q.wday <= nxt.wday & 8'h07;
      t_q.day  <= nxt.day  & 8'h3F;
      t_q.mon  <= nxt.mon  & 8'h1F;
      t_q.year <= nxt.year;
    end
  end

  a_r3_seconds_move: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && t_q.sec != 8'h59) |=> t_q.sec != $past(t_q.sec));
  a_r4_midnight_24h: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode24 && t_q.hour == 8'h23 && t_q.min == 8'h59 && t_q.sec == 8'h59)
      |=> t_q.hour == 8'h00);
  a_r8_weekday_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && t_q.wday <= 8'd6) |=> t_q.wday <= 8'd6);
endmodule

// File: rtl/tk_alarm.sv
module tk_alarm
  import tk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       alm_en,
  input  logic       roll_evt,
  input  tk_time_t   nxt,
  output logic [6:0] amin,
  output logic [5:0] ahour,
  output logic [6:0] amask,
  output logic       match,
  output logic       flag
);
  logic [7:0] mask8;
  logic       clr;

  assign mask8 = {1'b0, amask};
  assign match = roll_evt && alm_en && (nxt.min == {1'b0, amin}) &&
                 (nxt.hour == {2'b00, ahour}) && mask8[nxt.wday[2:0]];
  assign clr   = we && ((addr == A_CTRL2 && !wdata[C2_ALM]) ||
                        (addr == A_CTRL1 && !wdata[C1_ALM_EN]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amin  <= '0;
      ahour <= '0;
      amask <= '0;
      flag  <= 1'b0;
    end else begin
      if (we && addr == A_AMIN)  amin  <= wdata[6:0];
      if (we && addr == A_AHOUR) ahour <= wdata[5:0];
      if (we && addr == A_AMASK) amask <= wdata[6:0];
      if (clr)        flag <= 1'b0;
      else if (match) flag <= 1'b1;
    end
  end

  a_r10_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !clr) |=> flag);
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pre_tick,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       alarm_irq_n,
  output logic       periodic_irq_n
);
  tk_time_t   cur, nxt;
  logic       sec_tick, tick_eff, cal_wr, sec_wr, roll_evt;
  logic       alm_en_q, mode24_q, osc_q, per_q, alm_flag, alm_match;
  logic [2:0] per_sel_q;
  logic [7:0] trim_q;
  logic [6:0] amin, amask;
  logic [5:0] ahour;
  logic       c1_wr, c2_wr;

  assign cal_wr   = reg_we && (reg_addr <= A_YEAR);
  assign sec_wr   = reg_we && (reg_addr == A_SEC);
  assign tick_eff = sec_tick && !cal_wr;
  assign roll_evt = tick_eff && (cur.sec == 8'h59);
  assign c1_wr    = reg_we && (reg_addr == A_CTRL1);
  assign c2_wr    = reg_we && (reg_addr == A_CTRL2);

  tk_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .restart(sec_wr),
    .sec_tick(sec_tick));

  tk_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(tick_eff), .mode24(mode24_q),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .cur(cur), .nxt(nxt));

  tk_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .alm_en(alm_en_q), .roll_evt(roll_evt), .nxt(nxt), .amin(amin),
    .ahour(ahour), .amask(amask), .match(alm_match), .flag(alm_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_en_q  <= 1'b0;
      mode24_q  <= 1'b0;
      per_sel_q <= 3'd0;
      osc_q     <= 1'b1;
      per_q     <= 1'b0;
      trim_q    <= 8'h00;
    end else begin
      if (c1_wr) begin
        alm_en_q  <= reg_wdata[C1_ALM_EN];
        mode24_q  <= reg_wdata[C1_MODE24];
        per_sel_q <= reg_wdata[2:0];
      end
      if (reg_we && reg_addr == A_TRIM) trim_q <= reg_wdata;
      if (c2_wr) osc_q <= osc_q & reg_wdata[C2_OSC];
      if (c2_wr && !reg_wdata[C2_PER])                  per_q <= 1'b0;
      else if (tick_eff && per_sel_q == PER_SEL_1HZ)    per_q <= 1'b1;
    end
  end

  assign alarm_irq_n    = !(alm_flag && alm_en_q);
  assign periodic_irq_n = !(per_q && per_sel_q == PER_SEL_1HZ);

  always_comb begin
    case (reg_addr)
      A_SEC:   reg_rdata = cur.sec;
      A_MIN:   reg_rdata = cur.min;
      A_HOUR:  reg_rdata = cur.hour;
      A_WDAY:  reg_rdata = cur.wday;
      A_DAY:   reg_rdata = cur.day;
      A_MON:   reg_rdata = cur.mon;
      A_YEAR:  reg_rdata = cur.year;
      A_TRIM:  reg_rdata = trim_q;
      A_AMIN:  reg_rdata = {1'b0, amin};
      A_AHOUR: reg_rdata = {2'b00, ahour};
      A_AMASK: reg_rdata = {1'b0, amask};
      A_CTRL1: reg_rdata = {alm_en_q, 1'b0, mode24_q, 2'b00, per_sel_q};
      A_CTRL2: reg_rdata = {3'b000, osc_q, 1'b0, per_q, alm_flag, 1'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r11_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    alm_flag |-> alm_en_q);
  a_r9_osc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_q && !(c2_wr && !reg_wdata[C2_OSC])) |=> osc_q);
  a_r9_osc_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_q |=> !osc_q);
  a_r12_periodic_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_q) |-> $past(tick_eff));
endmodule

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_tick = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       alarm_irq_n, periodic_irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_timekeeper #(.TICKS_PER_SEC(DIV)) u_bcd_timekeeper (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_irq_n(alarm_irq_n), .periodic_irq_n(periodic_irq_n));

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, $sformatf("reg %0d", a), v, e);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pre_tick = 1'b1;
      @(negedge clk); pre_tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, w, h, mi, s);
    wr(4'd6, y); wr(4'd5, mo); wr(4'd4, d); wr(4'd3, w);
    wr(4'd2, h); wr(4'd1, mi); wr(4'd0, s);
  endtask

  task automatic expect_date(input string req, input logic [7:0] y, mo, d, w, h, mi, s);
    expect_reg(req, 4'd0, s); expect_reg(req, 4'd1, mi); expect_reg(req, 4'd2, h);
    expect_reg(req, 4'd3, w); expect_reg(req, 4'd4, d); expect_reg(req, 4'd5, mo);
    expect_reg(req, 4'd6, y);
  endtask

  task automatic t_reset;
    expect_date("R1", 8'h00, 8'h01, 8'h01, 8'h00, 8'h12, 8'h00, 8'h00);
    expect_reg("R1", 4'd7, 8'h00);
    expect_reg("R1", 4'd8, 8'h00);
    expect_reg("R1", 4'd10, 8'h00);
    expect_reg("R1", 4'd14, 8'h00);
    expect_reg("R1", 4'd15, 8'h10);
    check("R1", "alarm_irq_n", alarm_irq_n, 1'b1);
    check("R1", "periodic_irq_n", periodic_irq_n, 1'b1);
  endtask

  task automatic t_osc;
    wr(4'd15, 8'h10); expect_reg("R9", 4'd15, 8'h10);
    wr(4'd15, 8'h00); expect_reg("R9", 4'd15, 8'h00);
    wr(4'd15, 8'h10); expect_reg("R9", 4'd15, 8'h00);
  endtask

  task automatic t_masks;
    wr(4'd0, 8'hFF); expect_reg("R13", 4'd0, 8'h7F);
    wr(4'd2, 8'hFF); expect_reg("R13", 4'd2, 8'h3F);
    wr(4'd3, 8'hFF); expect_reg("R13", 4'd3, 8'h07);
    wr(4'd5, 8'hFF); expect_reg("R13", 4'd5, 8'h1F);
    wr(4'd7, 8'h5A); expect_reg("R13", 4'd7, 8'h5A);
    wr(4'd9, 8'hFF); expect_reg("R13", 4'd9, 8'h3F);
    wr(4'd12, 8'hAA); expect_reg("R13", 4'd12, 8'h00);
    wr(4'd14, 8'hFF); expect_reg("R13", 4'd14, 8'hA7);
    wr(4'd14, 8'h20); wr(4'd15, 8'h00);
  endtask

  task automatic t_prescaler;
    wr(4'd0, 8'h10);
    pulses(DIV - 1); expect_reg("R2", 4'd0, 8'h10);
    pulses(1);       expect_reg("R2", 4'd0, 8'h11);
    pulses(DIV - 2);
    wr(4'd0, 8'h20);
    pulses(DIV - 1); expect_reg("R2", 4'd0, 8'h20);
    pulses(1);       expect_reg("R2", 4'd0, 8'h21);
  endtask

  task automatic t_rollover;
    set_time(8'h24, 8'h03, 8'h15, 8'h01, 8'h00, 8'h10, 8'h59);
    pulses(DIV); expect_reg("R3", 4'd1, 8'h11); expect_reg("R3", 4'd0, 8'h00);
    set_time(8'h24, 8'h03, 8'h15, 8'h01, 8'h00, 8'h59, 8'h59);
    pulses(DIV); expect_date("R3", 8'h24, 8'h03, 8'h15, 8'h01, 8'h01, 8'h00, 8'h00);
  endtask

  task automatic t_24h;
    set_time(8'h24, 8'h03, 8'h15, 8'h01, 8'h23, 8'h59, 8'h59);
    pulses(DIV); expect_date("R4", 8'h24, 8'h03, 8'h16, 8'h02, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_12h;
    wr(4'd14, 8'h00);
    set_time(8'h24, 8'h03, 8'h10, 8'h03, 8'h11, 8'h59, 8'h59);
    pulses(DIV); expect_reg("R5", 4'd2, 8'h32); expect_reg("R5", 4'd4, 8'h10);
    set_time(8'h24, 8'h03, 8'h10, 8'h03, 8'h32, 8'h59, 8'h59);
    pulses(DIV); expect_reg("R5", 4'd2, 8'h21);
    set_time(8'h24, 8'h03, 8'h10, 8'h03, 8'h12, 8'h59, 8'h59);
    pulses(DIV); expect_reg("R5", 4'd2, 8'h01); expect_reg("R5", 4'd4, 8'h10);
    set_time(8'h24, 8'h03, 8'h10, 8'h03, 8'h31, 8'h59, 8'h59);
    pulses(DIV); expect_date("R5", 8'h24, 8'h03, 8'h11, 8'h04, 8'h12, 8'h00, 8'h00);
    wr(4'd14, 8'h20);
  endtask

  task automatic month_end(input string req, input logic [7:0] y, mo, d,
                           input logic [7:0] emo, ed);
    set_time(y, mo, d, 8'h00, 8'h23, 8'h59, 8'h59);
    pulses(DIV);
    expect_reg(req, 4'd4, ed); expect_reg(req, 4'd5, emo);
  endtask

  task automatic t_months;
    month_end("R6", 8'h24, 8'h04, 8'h30, 8'h05, 8'h01);
    month_end("R6", 8'h24, 8'h05, 8'h30, 8'h05, 8'h31);
    month_end("R6", 8'h24, 8'h05, 8'h31, 8'h06, 8'h01);
    month_end("R6", 8'h24, 8'h09, 8'h30, 8'h10, 8'h01);
    month_end("R6", 8'h24, 8'h11, 8'h30, 8'h12, 8'h01);
  endtask

  task automatic t_leap;
    month_end("R7", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end("R7", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    month_end("R7", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    month_end("R7", 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end("R7", 8'h10, 8'h02, 8'h28, 8'h03, 8'h01);
    month_end("R7", 8'h12, 8'h02, 8'h28, 8'h02, 8'h29);
  endtask

  task automatic t_wrap;
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    pulses(DIV); expect_date("R8", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic arm(input logic [7:0] mask);
    wr(4'd14, 8'h20);
    wr(4'd8, 8'h30); wr(4'd9, 8'h07); wr(4'd10, mask);
    set_time(8'h24, 8'h03, 8'h05, 8'h02, 8'h07, 8'h29, 8'h59);
  endtask

  task automatic t_alarm;
    arm(8'h7F); wr(4'd14, 8'hA0);
    pulses(DIV);
    expect_reg("R10", 4'd15, 8'h02);
    check("R10", "alarm_irq_n set", alarm_irq_n, 1'b0);
    wr(4'd15, 8'h00);
    expect_reg("R10", 4'd15, 8'h00);
    check("R10", "alarm_irq_n cleared", alarm_irq_n, 1'b1);
    pulses(DIV);
    expect_reg("R10", 4'd15, 8'h00);
  endtask

  task automatic t_alarm_block;
    arm(8'h7B); wr(4'd14, 8'hA0);
    pulses(DIV);
    expect_reg("R11", 4'd15, 8'h00);
    check("R11", "irq masked day", alarm_irq_n, 1'b1);
    arm(8'h7F);
    pulses(DIV);
    expect_reg("R11", 4'd15, 8'h00);
    check("R11", "irq disabled", alarm_irq_n, 1'b1);
    arm(8'h7F); wr(4'd14, 8'hA0);
    pulses(DIV);
    expect_reg("R11", 4'd15, 8'h02);
    wr(4'd14, 8'h20);
    expect_reg("R11", 4'd15, 8'h00);
    check("R11", "irq after disable", alarm_irq_n, 1'b1);
  endtask

  task automatic t_periodic;
    wr(4'd14, 8'h24);
    pulses(DIV);
    expect_reg("R12", 4'd15, 8'h04);
    check("R12", "periodic_irq_n set", periodic_irq_n, 1'b0);
    wr(4'd15, 8'h00);
    expect_reg("R12", 4'd15, 8'h00);
    check("R12", "periodic_irq_n cleared", periodic_irq_n, 1'b1);
    wr(4'd14, 8'h20);
    pulses(DIV);
    expect_reg("R12", 4'd15, 8'h00);
    check("R12", "periodic_irq_n off", periodic_irq_n, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_osc();
    t_masks();
    t_prescaler();
    t_rollover();
    t_24h();
    t_12h();
    t_months();
    t_leap();
    t_wrap();
    t_alarm();
    t_alarm_block();
    t_periodic();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule